// File: doc/BRIEF.md
# Programmable Receive Glitch Filter

This block cleans an asynchronous serial receive line before it reaches a bit sampler. The raw line first passes through a two-flop synchronizer. A 2-bit mode input then either bypasses filtering or picks one of three filter strengths. Each strength has a fixed maximum width of pulse that it removes and a fixed latency, the same for rising and falling edges. A pulse that is long enough to pass therefore keeps its width.

The filter holds a short history of the synchronized line in a delay line. The output moves to a new level only when the oldest sample in a window of the rejection width plus one samples starts a run of that level that fills the whole window. This places every accepted edge exactly one latency after the matching synchronized edge. When the mode changes, the whole history and the output register are loaded with the current synchronized level, so a steady line shows no false edge.

The rejection width per step is a parameter, `REJ_STEP`, with a default of 2 and a minimum of 2. Mode m rejects runs of up to `REJ_STEP*m` cycles and has a filter latency of twice that width minus one.

Top module: `rx_glitch_filter`

## Requirements
- R1: While `rst_n` is low, `rx_out` is 1 whatever `rx_in` is. After release, with `rx_in` held at 1, `rx_out` stays 1.
- R2: A two-flop synchronizer sits in front of the filter in every mode. In bypass, a level driven on `rx_in` in cycle c first appears on `rx_out` in cycle c+2, and this holds even for a one-cycle pulse.
- R3: With `mode` = 2'b00 there is no filtering: `rx_out` equals `rx_in` delayed by exactly 2 cycles, for any pulse width.
- R4: With `mode` = 2'b01, runs of 1 or 2 cycles have no effect on `rx_out`. Longer runs appear 3 cycles after the synchronizer, which is 5 cycles after `rx_in`.
- R5: With `mode` = 2'b10, runs of up to 4 cycles have no effect on `rx_out`. Longer runs appear 7 cycles after the synchronizer, which is 9 cycles after `rx_in`.
- R6: With `mode` = 2'b11, runs of up to 6 cycles have no effect on `rx_out`. Longer runs appear 11 cycles after the synchronizer, which is 13 cycles after `rx_in`.
- R7: In a filtering mode, a run one cycle longer than the rejection width reaches `rx_out` with its full width, delayed by that mode's latency. While the mode is steady, no output run is shorter than the rejection width plus one.
- R8: Rising and falling edges see the same latency in every filtering mode. A high pulse on a low idle line and a low pulse on a high idle line are treated alike.
- R9: In the cycle after `mode` differs from its registered copy, the whole filter state and the output are loaded with the current synchronized level. A line that is steady across the change gives no output edge, and the new mode's latency applies from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Filter strength: 00 bypass, 01/10/11 rising strength |
| rx_in | input | 1 | Raw asynchronous receive line |
| rx_out | output | 1 | Filtered receive line, idle high |

## Verification
Some properties are checked on every cycle. In bypass, the output must equal the input from two cycles earlier. Under a steady filtering mode, every output edge must match a synchronized edge exactly one mode latency earlier, and no output run may be shorter than the rejection width plus one. After a mode change to a filtering mode, the output must take the synchronized level. Only the bench scenarios can show which pulses are removed and which pass. They do this by driving runs exactly at the rejection width and one cycle beyond it, in both polarities and at every strength, and by holding the line low across a mode change.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    RXF_BYPASS = 2'b00,
    RXF_LIGHT  = 2'b01,
    RXF_MEDIUM = 2'b10,
    RXF_HEAVY  = 2'b11
  } rxf_mode_e;

  // Longest run (in cycles) that a mode swallows.
  function automatic int rej_width(input logic [1:0] m, input int step);
    return step * int'(m);
  endfunction

  // Cycles from the synchronized line to the output; zero in bypass.
  function automatic int filt_latency(input logic [1:0] m, input int step);
    return (m == 2'b00) ? 0 : 2 * rej_width(m, step) - 1;
  endfunction

endpackage

// File: rtl/rxf_sync2.sv
module rxf_sync2 #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE;
      q      <= IDLE;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/rxf_delay_line.sv
module rxf_delay_line #(
  parameter int DEPTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_val,
  input  logic             din,
  output logic [DEPTH:0]   taps
);
  logic [DEPTH:1] stage_q;

  // taps[i] is din delayed by i cycles; taps[0] is din itself.
  assign taps = {stage_q, din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stage_q <= '1;
    else if (load)  stage_q <= {DEPTH{load_val}};
    else            stage_q <= taps[DEPTH-1:0];
  end
endmodule

// File: rtl/rxf_window_judge.sv
module rxf_window_judge #(
  parameter int STEP  = 2,
  parameter int DEPTH = 10
) (
  input  logic [DEPTH:0] taps,
  input  logic [1:0]     mode,
  output logic           all_hi,
  output logic           all_lo
);
  // Index 0 stands for bypass and never agrees.
  logic [3:0] hi_m;
  logic [3:0] lo_m;

  assign hi_m[0] = 1'b0;
  assign lo_m[0] = 1'b0;

  // Window per strength: oldest tap (latency-1) back to W newer taps.
  for (genvar g = 1; g < 4; g++) begin : g_strength
    localparam int W      = STEP * g;
    localparam int OLDEST = 2 * W - 2;
    localparam int NEWEST = W - 2;
    assign hi_m[g] = &taps[OLDEST:NEWEST];
    assign lo_m[g] = ~|taps[OLDEST:NEWEST];
  end

  assign all_hi = hi_m[mode];
  assign all_lo = lo_m[mode];
endmodule

// File: rtl/rx_glitch_filter.sv
module rx_glitch_filter #(
  parameter int REJ_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       rx_in,
  output logic       rx_out
);
  import rxf_pkg::*;

  localparam int LINE_DEPTH = filt_latency(2'b11, REJ_STEP) - 1;

  // Named internal events
  logic                  sync_q;
  logic [1:0]            mode_q;
  logic                  mode_switch;
  logic                  reload;
  logic [LINE_DEPTH:0]   taps;
  logic                  win_hi;
  logic                  win_lo;
  logic                  out_q;

  rxf_sync2 #(.IDLE(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_in),
    .q     (sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= RXF_BYPASS;
    else        mode_q <= mode;
  end

  assign mode_switch = (mode != mode_q);
  // In bypass the history simply tracks the line so a later switch is clean.
  assign reload      = mode_switch || (mode_q == RXF_BYPASS);

  rxf_delay_line #(.DEPTH(LINE_DEPTH)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .load_val (sync_q),
    .din      (sync_q),
    .taps     (taps)
  );

  rxf_window_judge #(.STEP(REJ_STEP), .DEPTH(LINE_DEPTH)) u_judge (
    .taps   (taps),
    .mode   (mode_q),
    .all_hi (win_hi),
    .all_lo (win_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= 1'b1;
    else if (reload) out_q <= sync_q;
    else if (win_hi) out_q <= 1'b1;
    else if (win_lo) out_q <= 1'b0;
  end

  assign rx_out = (mode_q == RXF_BYPASS) ? sync_q : out_q;
endmodule

// File: rtl/rx_glitch_filter_chk.sv
module rx_glitch_filter_chk #(
  parameter int REJ_STEP = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [1:0] mode_q,
  input logic       rx_in,
  input logic       rx_out,
  input logic       sync_q,
  input logic       mode_switch
);
  import rxf_pkg::*;

  localparam int LMAX = filt_latency(2'b11, REJ_STEP);
  localparam int IW   = $clog2(LMAX + 2);

  int               age;
  int               steady;
  int               run;
  logic             last;
  logic [LMAX:0]    hs;
  int               cur_lat;
  int               cur_rej;
  logic [IW-1:0]    lat_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age    <= 0;
      steady <= 0;
      run    <= 0;
      last   <= 1'b1;
      hs     <= '1;
    end else begin
      if (age < 1000) age <= age + 1;
      if (mode_switch)          steady <= 0;
      else if (steady < 100000) steady <= steady + 1;
      if (rx_out != last)  run <= 1;
      else if (run < 100000) run <= run + 1;
      last <= rx_out;
      hs   <= {hs[LMAX-1:0], sync_q};
    end
  end

  always_comb begin
    cur_lat = filt_latency(mode_q, REJ_STEP);
    if (cur_lat < 1) cur_lat = 1;
    cur_rej = rej_width(mode_q, REJ_STEP);
    lat_i   = IW'(cur_lat);
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (rx_out === 1'b1); // R1
    end
  end

  AST_BYPASS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3 && mode_q == 2'b00) |-> (rx_out == $past(rx_in, 2))); // R3

  AST_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b00 && steady > LMAX + 2 && age > LMAX + 2 && rx_out != last)
    |-> (hs[lat_i - 1'b1] == rx_out && hs[lat_i] != rx_out)); // R8

  AST_MIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b00 && steady > run + LMAX + 2 && rx_out != last)
    |-> (run >= cur_rej + 1)); // R7

  AST_RELOAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 1 && mode_switch && mode != 2'b00) |=> (rx_out == $past(sync_q))); // R9

endmodule

bind rx_glitch_filter rx_glitch_filter_chk #(.REJ_STEP(REJ_STEP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .mode_q      (mode_q),
  .rx_in       (rx_in),
  .rx_out      (rx_out),
  .sync_q      (sync_q),
  .mode_switch (mode_switch)
);

// File: tb/rx_glitch_filter_test.sv
module rx_glitch_filter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       rx_in = 1'b0;
  logic       rx_out;

  rx_glitch_filter #(.REJ_STEP(2)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .rx_in  (rx_in),
    .rx_out (rx_out)
  );

  always #10 clk = ~clk; // 50 MHz

  typedef struct {
    int    cyc;
    logic  val;
    string req;
  } exp_t;

  exp_t  sbq[$];
  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  int    cur_mode = 0;
  logic  acc = 1'b1;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Bench's own view of the modes: rejected width and rx_in-to-rx_out delay.
  function automatic int bw(int m);
    return 2 * m;
  endfunction

  function automatic int dly(int m);
    if (m == 0) return 2;
    return 2 + (4 * m - 1);
  endfunction

  // Monitor: pop and compare as cycles arrive.
  always @(negedge clk) begin
    if (rst_n) begin
      while (sbq.size() > 0 && sbq[0].cyc < cyc) begin
        exp_t m;
        m = sbq.pop_front();
        checks++;
        failures++;
        $display("FAIL %s cycle %0d: sample missed, actual none expected %b", m.req, m.cyc, m.val);
      end
      if (sbq.size() > 0 && sbq[0].cyc == cyc) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (rx_out !== e.val) begin
          failures++;
          $display("FAIL %s cycle %0d: rx_out actual %b expected %b", e.req, cyc, rx_out, e.val);
        end
      end
    end
  end

  // Driver: one run of a level, expectations pushed one delay ahead.
  task automatic drive_run(input logic v, input int len, input string req);
    logic shown;
    shown = (len > bw(cur_mode)) ? v : acc;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_in = v;
      sbq.push_back('{cyc + dly(cur_mode), shown, req});
    end
    if (len > bw(cur_mode)) acc = v;
  endtask

  // Mode change with the line held: output must not move (R9).
  task automatic set_mode(input int m, input string req);
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    mode = 2'(m);
    cur_mode = m;
    for (int i = 1; i <= 30; i++) sbq.push_back('{cyc + i, acc, req});
    for (int i = 0; i < 30; i++) @(negedge clk);
  endtask

  task automatic direct_check(input logic expv, input string req);
    checks++;
    if (rx_out !== expv) begin
      failures++;
      $display("FAIL %s cycle %0d: rx_out actual %b expected %b", req, cyc, rx_out, expv);
    end
  endtask

  task automatic strength_sweep(input int m, input string req);
    int w;
    w = bw(m);
    set_mode(m, "R9");
    drive_run(1'b1, 30, req);
    drive_run(1'b0, 1, req);       // shortest glitch
    drive_run(1'b1, 30, req);
    drive_run(1'b0, w, req);       // exactly at the limit, removed
    drive_run(1'b1, 30, req);
    drive_run(1'b0, w + 1, "R7");  // one beyond, passes full width
    drive_run(1'b1, 30, "R7");
    drive_run(1'b0, 40, "R8");     // low idle
    drive_run(1'b1, w, req);       // high glitch at limit, removed
    drive_run(1'b0, 30, req);
    drive_run(1'b1, w + 1, "R8");  // high pulse, same latency
    drive_run(1'b0, 30, "R8");
    drive_run(1'b1, 40, "R8");
  endtask

  initial begin
    // R1: output idle-high under reset even with rx_in low
    rx_in = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      direct_check(1'b1, "R1");
    end
    rx_in = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 1; i <= 6; i++) sbq.push_back('{cyc + i, 1'b1, "R1"});
    for (int i = 0; i < 6; i++) @(negedge clk);

    // Bypass: every width passes after the two synchronizer cycles
    cur_mode = 0;
    drive_run(1'b1, 10, "R3");
    drive_run(1'b0, 1, "R2");
    drive_run(1'b1, 10, "R3");
    drive_run(1'b0, 3, "R3");
    drive_run(1'b1, 20, "R3");

    strength_sweep(1, "R4");
    strength_sweep(2, "R5");
    strength_sweep(3, "R6");

    // Mode change while the line sits low
    set_mode(0, "R9");
    drive_run(1'b0, 30, "R9");
    set_mode(3, "R9");
    drive_run(1'b0, 10, "R9");
    drive_run(1'b1, 30, "R9");
    set_mode(1, "R9");
    drive_run(1'b0, 3, "R9");
    drive_run(1'b1, 20, "R9");

    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule